// File: doc/BRIEF.md
# Calibration Pulse Train Generator

This block drives a front-end readout chain with a train of calibration pulses and, inside every pulse, a one-cycle trigger strobe placed a programmable number of cycles after the pulse's first cycle. Software-visible control words arrive as plain input ports. A three-bit control word gates the pulse output, gates the trigger output and carries a static fast-OR inhibit level. The remaining inputs are a start level, the pulse high time, the trigger offset, the number of pulses and the low time between pulses. Every interval is counted in cycles of the block's clock.

A train begins on a low-to-high transition of the start level. Timing values are captured at that moment, so later writes do not disturb a train in progress. A nonzero count gives a fixed-length train. A zero count keeps the train running while the start level stays high: the level is examined on the last cycle of each gap. Clearing the pulse enable bit abandons the train at once. A busy output covers the whole train, including the gap after the final pulse.

Top module: `calp_train_gen`

## Requirements
- R1: A train starts only when `launch_i` is high in a cycle where it was low in the previous cycle (it counts as low before the first cycle after reset) while the block is idle and `ctrl_i[0]` is high. `busy_o` and `cal_pulse_o` go high in the following cycle. A level held high never restarts a train, and a rising edge seen while `busy_o` is high is ignored.
- R2: While `ctrl_i[0]` is low, no train starts, whatever `launch_i` does.
- R3: Each pulse holds `cal_pulse_o` high for exactly `width_i` consecutive cycles. A width of 0 is treated as 1.
- R4: When `ctrl_i[1]` is high, `trig_o` is high for exactly one cycle in each pulse. That cycle is at offset `trig_delay_i` from the pulse's first cycle, where offset 0 is the first cycle. An offset of `width_i` or more is clamped to the pulse's last cycle. When `ctrl_i[1]` is low, `trig_o` stays low.
- R5: After every pulse, including the last one, `cal_pulse_o` stays low for exactly `gap_i` cycles, with `busy_o` still high. A gap of 0 is treated as 1.
- R6: A nonzero `pulse_count_i` yields exactly that many pulses.
- R7: With `pulse_count_i` equal to 0, `launch_i` is sampled on the last cycle of each gap. The train continues with a new pulse if it is high and ends if it is low.
- R8: If `ctrl_i[0]` is low at a clock edge, the next cycle has `busy_o`, `cal_pulse_o` and `trig_o` low.
- R9: `busy_o` is low after reset. During a train it is high for exactly N×(width+gap) cycles, using the effective values, where N is the number of pulses.
- R10: `fastor_inhibit_o` follows `ctrl_i[2]` combinationally.
- R11: Width, trigger offset, count, gap and the trigger enable bit `ctrl_i[1]` are captured at the start edge. Changing them during a train has no effect on that train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 3 | Bit 0 pulse enable, bit 1 trigger enable, bit 2 fast-OR inhibit level |
| launch_i | input | 1 | Start level; a rising edge begins a train |
| width_i | input | 32 | Pulse high time in cycles |
| trig_delay_i | input | 32 | Trigger offset from the first cycle of a pulse |
| pulse_count_i | input | 32 | Pulses per train; 0 means run while the start level is high |
| gap_i | input | 32 | Low time after each pulse in cycles |
| cal_pulse_o | output | 1 | Calibration pulse |
| trig_o | output | 1 | One-cycle trigger strobe |
| fastor_inhibit_o | output | 1 | Fast-OR trigger inhibit |
| busy_o | output | 1 | High while a train is in progress |

## Verification
Several properties are checked on every cycle. The trigger is only ever a single-cycle strobe that lies inside a pulse. The captured offset always falls inside the captured width. The pulse output never appears without busy. A cleared enable empties the block by the next cycle. An accepted edge opens a pulse one cycle later. The completed-pulse tally never runs past a nonzero count. Exact pulse lengths, gap lengths, trigger offsets, train lengths, the zero-count continue-or-stop decision, the rejection of edges during a train and the immunity to writes made mid-train can only be shown by the bench's scenarios.

// File: rtl/calp_pkg.sv
package calp_pkg;

    localparam int unsigned CALP_CW    = 32;
    localparam int unsigned CALP_CTL_W = 3;

    // Control word bit positions
    localparam int unsigned CTL_CAL_EN  = 0;
    localparam int unsigned CTL_TRIG_EN = 1;
    localparam int unsigned CTL_FOR_DIS = 2;

    typedef logic [CALP_CW-1:0] cyc_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_GAP   = 2'd2
    } phase_e;

    // Captured, already-cleaned train settings
    typedef struct packed {
        cyc_t width;
        cyc_t trig_at;
        cyc_t count;
        cyc_t gap;
        logic trig_en;
    } train_cfg_t;

    function automatic cyc_t at_least_one(input cyc_t v);
        return (v == '0) ? cyc_t'(1) : v;
    endfunction

    function automatic cyc_t clamp_trig(input cyc_t d, input cyc_t w_eff);
        return (d >= w_eff) ? (w_eff - cyc_t'(1)) : d;
    endfunction

endpackage

// File: rtl/calp_edge.sv
module calp_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R1: a held level produces a single edge indication
    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/calp_cfg_hold.sv
module calp_cfg_hold
    import calp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cyc_t       width_i,
    input  cyc_t       delay_i,
    input  cyc_t       count_i,
    input  cyc_t       gap_i,
    input  logic       trig_en_i,
    output train_cfg_t cfg
);
    train_cfg_t nxt;
    cyc_t       w_eff;

    always_comb begin
        w_eff       = at_least_one(width_i);
        nxt.width   = w_eff;
        nxt.trig_at = clamp_trig(delay_i, w_eff);
        nxt.count   = count_i;
        nxt.gap     = at_least_one(gap_i);
        nxt.trig_en = trig_en_i;
    end

    always_ff @(posedge clk) begin
        if (rst)       cfg <= '0;
        else if (load) cfg <= nxt;
    end

    // R3: a captured width is never zero
    p_width_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg.width != '0));

    // R4: captured trigger offset always lands inside the pulse
    p_trig_clamped_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.width != '0) |-> (cfg.trig_at < cfg.width));

endmodule

// File: rtl/calp_seq.sv
module calp_seq
    import calp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       start_rise,
    input  logic       lvl,
    input  train_cfg_t cfg,
    output logic       load,
    output logic       cal_pulse,
    output logic       trig_out,
    output logic       busy
);
    phase_e phase;
    cyc_t   tick;
    cyc_t   done;
    logic   pulse_end;
    logic   gap_end;
    logic   last_one;

    assign load      = (phase == PH_IDLE) & en & start_rise;
    assign pulse_end = (tick == cfg.width - cyc_t'(1));
    assign gap_end   = (tick == cfg.gap - cyc_t'(1));
    assign last_one  = (cfg.count != '0) ? (done == cfg.count) : ~lvl;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= PH_IDLE;
            tick  <= '0;
            done  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start_rise) begin
                        phase <= PH_PULSE;
                        tick  <= '0;
                        done  <= '0;
                    end
                end
                PH_PULSE: begin
                    if (pulse_end) begin
                        phase <= PH_GAP;
                        tick  <= '0;
                        done  <= done + cyc_t'(1);
                    end else begin
                        tick <= tick + cyc_t'(1);
                    end
                end
                PH_GAP: begin
                    if (gap_end) begin
                        tick  <= '0;
                        phase <= last_one ? PH_IDLE : PH_PULSE;
                    end else begin
                        tick <= tick + cyc_t'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    tick  <= '0;
                    done  <= '0;
                end
            endcase
        end
    end

    assign cal_pulse = (phase == PH_PULSE);
    assign trig_out  = cal_pulse & cfg.trig_en & (tick == cfg.trig_at);
    assign busy      = (phase != PH_IDLE);

    // R4: trigger strobe never lasts two cycles
    p_trig_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    // R5: the last pulse cycle is followed by a gap
    p_pulse_then_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && pulse_end && en) |=> (phase == PH_GAP));

    // R6: completed pulses never exceed a nonzero count
    p_done_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && cfg.count != '0) |-> (done <= cfg.count));

endmodule

// File: rtl/calp_train_gen.sv
module calp_train_gen
    import calp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CALP_CTL_W-1:0] ctrl_i,
    input  logic                  launch_i,
    input  logic [CALP_CW-1:0]    width_i,
    input  logic [CALP_CW-1:0]    trig_delay_i,
    input  logic [CALP_CW-1:0]    pulse_count_i,
    input  logic [CALP_CW-1:0]    gap_i,
    output logic                  cal_pulse_o,
    output logic                  trig_o,
    output logic                  fastor_inhibit_o,
    output logic                  busy_o
);
    logic       rise;
    logic       load;
    train_cfg_t cfg;

    calp_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (launch_i),
        .rise (rise)
    );

    calp_cfg_hold u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .width_i   (width_i),
        .delay_i   (trig_delay_i),
        .count_i   (pulse_count_i),
        .gap_i     (gap_i),
        .trig_en_i (ctrl_i[CTL_TRIG_EN]),
        .cfg       (cfg)
    );

    calp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl_i[CTL_CAL_EN]),
        .start_rise (rise),
        .lvl        (launch_i),
        .cfg        (cfg),
        .load       (load),
        .cal_pulse  (cal_pulse_o),
        .trig_out   (trig_o),
        .busy       (busy_o)
    );

    assign fastor_inhibit_o = ctrl_i[CTL_FOR_DIS];

    // R1: an accepted edge opens a pulse on the next cycle
    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && ctrl_i[CTL_CAL_EN] && rise) |=> (busy_o && cal_pulse_o));

    // R8: cleared enable empties the block by the next cycle
    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i[CTL_CAL_EN] |=> (!busy_o && !cal_pulse_o && !trig_o));

    // R9: a pulse only appears inside a busy window
    p_pulse_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        cal_pulse_o |-> busy_o);

    // R4: trigger lies within a pulse
    p_trig_in_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> cal_pulse_o);

endmodule

// File: tb/tb_calp_train_gen.sv
`timescale 1ns/1ps
module tb_calp_train_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ctrl = 3'b000;
    logic        launch = 1'b0;
    logic [31:0] width = '0, tdly = '0, pcount = '0, gap = '0;
    logic        cal, trig, finh, busy;

    int n_tot = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    calp_train_gen dut (
        .clk              (clk),
        .rst              (rst),
        .ctrl_i           (ctrl),
        .launch_i         (launch),
        .width_i          (width),
        .trig_delay_i     (tdly),
        .pulse_count_i    (pcount),
        .gap_i            (gap),
        .cal_pulse_o      (cal),
        .trig_o           (trig),
        .fastor_inhibit_o (finh),
        .busy_o           (busy)
    );

    // Columns: ctrl, width, delay, count, gap, hold,
    //          exp pulses, exp width, exp offset, exp trigs, exp gap, exp busy
    localparam int VTAB [0:6][0:11] = '{
        '{3, 4, 1, 3, 2, 40,  3, 4, 1, 3, 2, 18},
        '{3, 5, 9, 2, 3, 40,  2, 5, 4, 2, 3, 16},
        '{1, 2, 0, 4, 1, 40,  4, 2, 0, 0, 1, 12},
        '{3, 0, 0, 1, 0, 40,  1, 1, 0, 1, 1,  2},
        '{3, 3, 2, 0, 2, 12,  3, 3, 2, 3, 2, 15},
        '{7, 1, 5, 2, 1, 40,  2, 1, 0, 2, 1,  4},
        '{3, 3, 3, 1, 4,  2,  1, 3, 2, 1, 4,  7}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] c, input int w, input int d, input int n, input int g);
        ctrl   = c;
        width  = w;
        tdly   = d;
        pcount = n;
        gap    = g;
    endtask

    // kind 0: plain; 1: retoggle launch at sample 'at'; 2: rewrite settings at sample 'at'
    task automatic run_train(input string ctag, input int e_np, input int e_w, input int e_d,
                             input int e_tr, input int e_g, input int e_busy,
                             input int hold, input int kind, input int at);
        int np = 0, pos = 0, low_run = 0, busy_len = 0, ntr = 0;
        int bad_w = 0, bad_tr = 0, bad_g = 0, last_s = 0, stray = 0;
        bit pc = 1'b0;
        @(negedge clk);
        launch = 1'b1;
        for (int s = 1; s <= 600; s++) begin
            @(negedge clk);
            if (busy) busy_len++;
            if (cal) begin
                if (!pc) begin
                    if (np > 0 && low_run != e_g) bad_g++;
                    np++;
                    pos = 0;
                    low_run = 0;
                end else begin
                    pos++;
                end
            end else begin
                if (pc && (pos + 1) != e_w) bad_w++;
                if (busy) low_run++;
            end
            if (trig) begin
                ntr++;
                if (!cal || pos != e_d) bad_tr++;
            end
            pc = cal;
            if (kind == 1 && s == at) launch = 1'b0;
            if (kind == 1 && s == at + 1) launch = 1'b1;
            if (kind == 2 && s == at) set_cfg(3'b001, 9, 0, 5, 7);
            if (s == hold) launch = 1'b0;
            last_s = s;
            if (!busy) break;
        end
        if (np > 0 && low_run != e_g) bad_g++;
        chk(np == e_np, {ctag, " pulse count"}, np, e_np);
        chk(bad_w == 0, "R3 pulse width mismatches", bad_w, 0);
        chk(ntr == e_tr, "R4 trigger count", ntr, e_tr);
        chk(bad_tr == 0, "R4 misplaced triggers", bad_tr, 0);
        chk(bad_g == 0, "R5 gap length mismatches", bad_g, 0);
        chk(busy_len == e_busy, "R9 busy length", busy_len, e_busy);
        if (last_s < hold && launch) begin
            repeat (4) begin
                @(negedge clk);
                if (busy) stray++;
            end
            chk(stray == 0, "R1 held level restarted train", stray, 0);
        end
        launch = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tot++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy after reset", busy, 0);
        chk(cal == 1'b0, "R9 pulse after reset", cal, 0);
        chk(trig == 1'b0, "R9 trigger after reset", trig, 0);

        // R10 fast-OR inhibit pass-through
        ctrl = 3'b100;
        #1;
        chk(finh == 1'b1, "R10 inhibit high", finh, 1);
        ctrl = 3'b000;
        #1;
        chk(finh == 1'b0, "R10 inhibit low", finh, 0);

        // Table-driven trains
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            set_cfg(VTAB[v][0][2:0], VTAB[v][1], VTAB[v][2], VTAB[v][3], VTAB[v][4]);
            if (VTAB[v][0][2]) begin
                #1;
                chk(finh == 1'b1, "R10 inhibit during train setup", finh, 1);
            end
            run_train((VTAB[v][3] == 0) ? "R7" : "R6",
                      VTAB[v][6], VTAB[v][7], VTAB[v][8], VTAB[v][9],
                      VTAB[v][10], VTAB[v][11], VTAB[v][5], 0, 0);
        end

        // R2: enable low blocks starting
        @(negedge clk);
        set_cfg(3'b010, 3, 0, 1, 1);
        launch = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy with enable low", busy, 0);
        @(negedge clk);
        chk(cal == 1'b0, "R2 pulse with enable low", cal, 0);
        launch = 1'b0;
        repeat (2) @(negedge clk);

        // R8: abort mid-pulse
        set_cfg(3'b011, 10, 0, 2, 2);
        launch = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after accepted edge", busy, 1);
        @(negedge clk);
        @(negedge clk);
        ctrl = 3'b010;
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy after abort", busy, 0);
        chk(cal == 1'b0, "R8 pulse after abort", cal, 0);
        ctrl = 3'b011;
        @(negedge clk);
        chk(busy == 1'b0, "R1 no restart on held level", busy, 0);
        launch = 1'b0;
        repeat (2) @(negedge clk);

        // R1: edge during a train is ignored
        set_cfg(3'b011, 6, 0, 1, 2);
        run_train("R1 edge while busy", 1, 6, 0, 1, 2, 8, 40, 1, 2);

        // R11: settings rewritten mid-train have no effect
        set_cfg(3'b011, 4, 1, 2, 2);
        run_train("R11 captured settings", 2, 4, 1, 2, 2, 12, 40, 2, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

endmodule